// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Unit

This block connects a core's load/store datapath to a word-wide data memory that is addressed by bytes. For each request it adds a sign-extended offset to a base address to form the effective address. It then sends the word address to the memory and decides which byte lanes take part in the access. Byte order is big endian, so the byte at the lowest address of a word travels on the most significant data bits.

A store writes only the low byte or the low halfword of its data operand. The unit copies that byte or halfword onto every lane where it could land and raises only the matching byte-write enables. A load is issued to a memory with one cycle of read latency. The unit keeps the low address bits, the size and the signedness of the load in registers. When the word returns one cycle later, the unit picks the addressed byte or halfword from it and sign- or zero-extends it, all in combinational logic.

A halfword access at an odd address, or a word access at an address that is not a multiple of four, is flagged as misaligned in the same cycle. Such an access is not issued to memory and writes nothing.

Top module: `be_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to the address width, modulo 2^ADDR_W. `mem_addr` carries that address with its two low bits removed.
- R2: A byte store (`req_size` 00) sets exactly one bit of `mem_be`, bit k for byte offset k. Bit k enables data bits 31-8k down to 24-8k, so offset 0 is bits 31:24. `mem_wdata` holds `req_wdata[7:0]` in every lane.
- R3: A halfword store (`req_size` 01) at offset 0 gives `mem_be` = 0011, and at offset 2 gives 1100. `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R4: A word store (`req_size` 1x, so both 10 and 11) gives `mem_be` = 1111 and `mem_wdata` = `req_wdata`.
- R5: `misalign` is high in the same cycle as a valid request whose size is halfword with address bit 0 set, or word with either of address bits 1:0 set. When it is high, `mem_en` is low and `mem_be` is zero, and a later load shows that memory is unchanged. `misalign` is low whenever `req_valid` is low.
- R6: An aligned load drives `mem_en` high with `mem_be` zero. `ld_valid` is high exactly one cycle after each aligned load request and at no other time. A misaligned load gives no `ld_valid`.
- R7: A byte load returns the byte at its big-endian lane of `mem_rdata`. With `req_signed` = 1 the byte is sign-extended to 32 bits, and with 0 it is zero-extended.
- R8: A halfword load returns `mem_rdata[31:16]` at offset 0 or `mem_rdata[15:0]` at offset 2, sign- or zero-extended as `req_signed` selects.
- R9: A word load returns `mem_rdata` unchanged, whatever the value of `req_signed`.
- R10: While `rst_n` is low at a clock edge, and in the cycle after, `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_base | input | ADDR_W | Base address operand |
| req_offset | input | OFF_W | Signed displacement |
| req_wdata | input | DATA_W | Store operand (low bits used for narrow stores) |
| mem_en | output | 1 | Memory access strobe |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | DATA_W/8 | Byte-write enables, bit k = byte offset k |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Word read, valid one cycle after `mem_en` |
| misalign | output | 1 | Current request is misaligned |
| ld_valid | output | 1 | `ld_data` holds a load result |
| ld_data | output | DATA_W | Extended load value |

## Verification
The bench builds the unit with its default widths: 32-bit data, a 32-bit address and a 16-bit displacement. With these widths the bench can reach displacements that go negative, effective addresses that wrap past the top of the 32-bit space, and all four byte lanes in both byte and halfword form. The bench keeps a byte-level model of memory and checks every store by reading it back through the load path. It runs back-to-back loads to test that the registered low address bits follow the correct request. It also sends misaligned requests of every size and then reads the target word to show that nothing was written.

// File: rtl/be_lane_pkg.sv
// Shared size encoding for the byte-lane unit.
// Assumes a two-bit size field where the upper bit alone selects a full word.
package be_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    // True when the size code selects a full-width access.
    function automatic logic size_is_full(input logic [1:0] sz);
        return sz[1];
    endfunction

    // True when the size code selects a halfword access.
    function automatic logic size_is_half(input logic [1:0] sz);
        return (sz == SZ_HALF);
    endfunction

endpackage

// File: rtl/be_lane_agen.sv
// Effective-address generator and alignment check.
// Adds a sign-extended displacement to the base and splits the result into a
// word address and a lane offset. Assumes LOFF_W >= 2.
module be_lane_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LOFF_W = 2
) (
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic [1:0]               size_i,
    output logic [ADDR_W-LOFF_W-1:0] word_addr_o,
    output logic [LOFF_W-1:0]        lane_off_o,
    output logic                     bad_align_o
);
    import be_lane_pkg::*;

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff_addr;

    // Form the effective byte address.
    always_comb begin
        eff_addr = base_i + {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    end

    assign word_addr_o = eff_addr[ADDR_W-1:LOFF_W];
    assign lane_off_o  = eff_addr[LOFF_W-1:0];

    // Flag accesses whose offset does not suit their size.
    always_comb begin
        if (size_is_full(size_i))
            bad_align_o = |eff_addr[LOFF_W-1:0];
        else if (size_is_half(size_i))
            bad_align_o = eff_addr[0];
        else
            bad_align_o = 1'b0;
    end

endmodule

// File: rtl/be_lane_store.sv
// Store lane steering: copies the narrow operand onto every lane it could
// occupy and raises the write enables of the addressed lanes only.
// Lane k is byte offset k and uses data bits DATA_W-1-8k down to DATA_W-8-8k.
module be_lane_store #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int LOFF_W = 2
) (
    input  logic              wr_ok_i,
    input  logic [1:0]        size_i,
    input  logic [LOFF_W-1:0] lane_off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o
);
    import be_lane_pkg::*;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI  = k / 2;
        localparam int MSB = DATA_W - 1 - 8 * k;

        logic byte_hit;
        logic half_hit;

        // Decode whether this lane is addressed for each narrow size.
        always_comb begin
            byte_hit = (int'(lane_off_i) == k);
            half_hit = (int'(lane_off_i[LOFF_W-1:1]) == HI);
        end

        // Enable this lane for the addressed bytes of a permitted store.
        always_comb begin
            if (size_is_full(size_i))
                be_o[k] = wr_ok_i;
            else if (size_is_half(size_i))
                be_o[k] = wr_ok_i & half_hit;
            else
                be_o[k] = wr_ok_i & byte_hit;
        end

        // Pick the operand byte this lane carries.
        always_comb begin
            if (size_is_full(size_i))
                wdata_o[MSB -: 8] = wdata_i[MSB -: 8];
            else if (size_is_half(size_i))
                wdata_o[MSB -: 8] = (k % 2 == 0) ? wdata_i[15:8] : wdata_i[7:0];
            else
                wdata_o[MSB -: 8] = wdata_i[7:0];
        end
    end

endmodule

// File: rtl/be_lane_load.sv
// Load extraction: picks the addressed byte or halfword from a returned word
// in big-endian lane order and extends it to full width.
// Assumes the lane offset, size and signedness are already registered.
module be_lane_load #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int LOFF_W = 2
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [LOFF_W-1:0] lane_off_i,
    input  logic [1:0]        size_i,
    input  logic              sign_i,
    output logic [DATA_W-1:0] data_o
);
    import be_lane_pkg::*;

    logic [7:0]  lane_b [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;
    logic [LOFF_W-1:0] hi_lane;
    logic [LOFF_W-1:0] lo_lane;

    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign lane_b[k] = rdata_i[DATA_W-1-8*k -: 8];
    end

    // Select the addressed byte and halfword.
    always_comb begin
        hi_lane = {lane_off_i[LOFF_W-1:1], 1'b0};
        lo_lane = {lane_off_i[LOFF_W-1:1], 1'b1};
        pick_b  = lane_b[lane_off_i];
        pick_h  = {lane_b[hi_lane], lane_b[lo_lane]};
    end

    // Extend the selected field to the data width.
    always_comb begin
        if (size_is_full(size_i))
            data_o = rdata_i;
        else if (size_is_half(size_i))
            data_o = {{(DATA_W-16){sign_i & pick_h[15]}}, pick_h};
        else
            data_o = {{(DATA_W-8){sign_i & pick_b[7]}}, pick_b};
    end

endmodule

// File: rtl/be_lane_unit.sv
// Top of the big-endian byte-lane unit. Stores and the alignment check are
// combinational on the request. Loads register the lane offset, size and
// signedness, then extract from the memory word one cycle later.
// Assumes a memory with one cycle of read latency. Reset is synchronous, active low.
module be_lane_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic                       req_signed,
    input  logic [ADDR_W-1:0]          req_base,
    input  logic [OFF_W-1:0]           req_offset,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       mem_en,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W/8-1:0]        mem_be,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       misalign,
    output logic                       ld_valid,
    output logic [DATA_W-1:0]          ld_data
);
    localparam int LANES   = DATA_W / 8;
    localparam int LOFF_W  = $clog2(LANES);
    localparam int WADDR_W = ADDR_W - LOFF_W;

    logic [WADDR_W-1:0] word_addr;
    logic [LOFF_W-1:0]  lane_off;
    logic               bad_align;
    logic               accept;
    logic               wr_ok;
    logic               rd_ok;

    logic               pend_v;
    logic [LOFF_W-1:0]  pend_off;
    logic [1:0]         pend_size;
    logic               pend_sign;

    be_lane_agen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LOFF_W (LOFF_W)
    ) u_agen (
        .base_i      (req_base),
        .offset_i    (req_offset),
        .size_i      (req_size),
        .word_addr_o (word_addr),
        .lane_off_o  (lane_off),
        .bad_align_o (bad_align)
    );

    // Qualify the request against the alignment check.
    always_comb begin
        accept   = req_valid & ~bad_align;
        wr_ok    = accept & req_write;
        rd_ok    = accept & ~req_write;
        misalign = req_valid & bad_align;
        mem_en   = accept;
        mem_addr = word_addr;
    end

    be_lane_store #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LOFF_W (LOFF_W)
    ) u_store (
        .wr_ok_i    (wr_ok),
        .size_i     (req_size),
        .lane_off_i (lane_off),
        .wdata_i    (req_wdata),
        .be_o       (mem_be),
        .wdata_o    (mem_wdata)
    );

    // Track that a load result is due next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_v <= 1'b0;
        else
            pend_v <= rd_ok;
    end

    // Hold the extraction controls of the load in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_off  <= '0;
            pend_size <= '0;
            pend_sign <= 1'b0;
        end else if (rd_ok) begin
            pend_off  <= lane_off;
            pend_size <= req_size;
            pend_sign <= req_signed;
        end
    end

    be_lane_load #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LOFF_W (LOFF_W)
    ) u_load (
        .rdata_i    (mem_rdata),
        .lane_off_i (pend_off),
        .size_i     (pend_size),
        .sign_i     (pend_sign),
        .data_o     (ld_data)
    );

    assign ld_valid = pend_v;

endmodule

// File: rtl/be_lane_unit_chk.sv
// Property checker for the byte-lane unit, attached by bind.
// Observes only the top-level ports.
module be_lane_unit_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_size,
    input logic             mem_en,
    input logic [LANES-1:0] mem_be,
    input logic             misalign,
    input logic             ld_valid
);
    logic st_ok;
    assign st_ok = req_valid && req_write && !misalign;

    p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ok && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    p_half_two_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ok && req_size == 2'b01) |-> ($countones(mem_be) == 2));

    p_word_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ok && req_size[1]) |-> (&mem_be));

    p_misalign_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_en && mem_be == '0));

    p_misalign_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !misalign);

    p_load_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (mem_be == '0));

    p_load_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !misalign) |=> ld_valid);

    p_load_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_write && !misalign));

endmodule

bind be_lane_unit be_lane_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .mem_en    (mem_en),
    .mem_be    (mem_be),
    .misalign  (misalign),
    .ld_valid  (ld_valid)
);

// File: tb/be_lane_unit_tb_top.sv
// Bench for the byte-lane unit: byte-level reference memory, request-by-request
// expectations, and a one-cycle-latency memory behind the unit.
module be_lane_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_signed;
    logic [1:0]  req_size;
    logic [31:0] req_base;
    logic [15:0] req_offset;
    logic [31:0] req_wdata;
    logic        mem_en;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        misalign, ld_valid;
    logic [31:0] ld_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] bmem    [64];
    logic [7:0] ref_mem [64];

    bit          exp_pend = 0;
    logic [31:0] exp_val;
    string       exp_tag;

    always #5 clk = ~clk;

    be_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata), .mem_en(mem_en),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .misalign(misalign), .ld_valid(ld_valid),
        .ld_data(ld_data)
    );

    // Data memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) bmem[int'(mem_addr[3:0])*4+k] <= mem_wdata[31-8*k -: 8];
            mem_rdata <= {bmem[int'(mem_addr[3:0])*4], bmem[int'(mem_addr[3:0])*4+1],
                          bmem[int'(mem_addr[3:0])*4+2], bmem[int'(mem_addr[3:0])*4+3]};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: check the result due from the previous load, drive the
    // new request, check the request-side outputs, then update the model.
    task automatic step(input bit v, input bit w, input logic [1:0] sz, input bit sg,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] wd);
        logic [31:0] ea;
        bit          bad, ok;
        int          a;
        logic [3:0]  ebe;
        logic [31:0] ewd, val;
        string       tag;
        @(negedge clk);
        if (exp_pend) begin
            chk({exp_tag, " ld_valid"}, {31'b0, ld_valid}, 32'd1);
            chk({exp_tag, " ld_data"}, ld_data, exp_val);
        end else begin
            chk("R6 no ld_valid", {31'b0, ld_valid}, 32'd0);
        end
        req_valid = v; req_write = w; req_size = sz; req_signed = sg;
        req_base = base; req_offset = off; req_wdata = wd;
        ea  = base + {{16{off[15]}}, off};
        bad = v && ((sz[1] && ea[1:0] != 0) || (sz == 2'b01 && ea[0]));
        ok  = v && !bad;
        a   = int'(ea[5:0]);
        #1;
        chk("R5 misalign", {31'b0, misalign}, {31'b0, bad});
        chk(w ? "R5 mem_en" : "R6 mem_en", {31'b0, mem_en}, {31'b0, ok});
        if (ok) chk("R1 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
        ebe = 4'b0000;
        ewd = wd;
        tag = bad ? "R5" : (w ? (sz[1] ? "R4" : (sz[0] ? "R3" : "R2")) : "R6");
        if (ok && w) begin
            if (sz[1]) begin
                ebe = 4'b1111; ewd = wd;
                for (int k = 0; k < 4; k++) ref_mem[a+k] = wd[31-8*k -: 8];
            end else if (sz[0]) begin
                ebe = ea[1] ? 4'b1100 : 4'b0011; ewd = {wd[15:0], wd[15:0]};
                ref_mem[a] = wd[15:8]; ref_mem[a+1] = wd[7:0];
            end else begin
                ebe = 4'b0001 << ea[1:0]; ewd = {4{wd[7:0]}};
                ref_mem[a] = wd[7:0];
            end
            chk({tag, " mem_wdata"}, mem_wdata, ewd);
        end
        chk({tag, " mem_be"}, {28'b0, mem_be}, {28'b0, ebe});
        exp_pend = ok && !w;
        if (exp_pend) begin
            if (sz[1]) begin
                val = {ref_mem[a], ref_mem[a+1], ref_mem[a+2], ref_mem[a+3]};
                exp_tag = "R9";
            end else if (sz[0]) begin
                val = {{16{sg & ref_mem[a][7]}}, ref_mem[a], ref_mem[a+1]};
                exp_tag = "R8";
            end else begin
                val = {{24{sg & ref_mem[a][7]}}, ref_mem[a]};
                exp_tag = "R7";
            end
            exp_val = val;
        end
    endtask

    localparam logic [31:0] B = 32'h1000_0000;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 8'(i * 37 + 5);
            ref_mem[i] = 8'(i * 37 + 5);
        end
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
        req_base = 0; req_offset = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'd0);

        // Word store and read-back, every byte and lane signed and unsigned.
        step(1, 1, 2'b10, 0, B, 16'h0000, 32'hA1B2_C3D4);
        step(1, 0, 2'b10, 1, B, 16'h0000, 0);
        for (int o = 0; o < 4; o++) begin
            step(1, 0, 2'b00, 1, B, 16'(o), 0);
            step(1, 0, 2'b00, 0, B, 16'(o), 0);
        end
        // Positive and negative bytes in one word.
        step(1, 1, 2'b10, 0, B, 16'h0004, 32'h7F80_017E);
        for (int o = 4; o < 8; o++) step(1, 0, 2'b00, 1, B, 16'(o), 0);
        // Halfword stores and loads.
        step(1, 1, 2'b01, 0, B, 16'h0008, 32'hDEAD_8001);
        step(1, 1, 2'b01, 0, B, 16'h000A, 32'h0000_7FFF);
        step(1, 0, 2'b01, 1, B, 16'h0008, 0);
        step(1, 0, 2'b01, 0, B, 16'h0008, 0);
        step(1, 0, 2'b01, 1, B, 16'h000A, 0);
        step(1, 0, 2'b10, 0, B, 16'h0008, 0);
        // Byte stores use only the low byte; neighbours untouched.
        step(1, 1, 2'b10, 0, B, 16'h000C, 32'h0102_0304);
        step(1, 1, 2'b00, 0, B, 16'h000D, 32'hFFFF_FF5A);
        step(1, 1, 2'b00, 0, B, 16'h000F, 32'h1234_56C3);
        step(1, 0, 2'b10, 0, B, 16'h000C, 0);
        // Misaligned requests of each kind, then prove nothing changed.
        step(1, 1, 2'b01, 0, B, 16'h000D, 32'hFFFF_FFFF);
        step(1, 1, 2'b10, 0, B, 16'h000E, 32'hFFFF_FFFF);
        step(1, 1, 2'b11, 0, B, 16'h000F, 32'hFFFF_FFFF);
        step(1, 0, 2'b10, 0, B, 16'h0002, 0);
        step(1, 0, 2'b01, 1, B, 16'h0001, 0);
        step(1, 0, 2'b10, 1, B, 16'h000C, 0);
        // Alternate word code.
        step(1, 1, 2'b11, 0, B, 16'h0010, 32'h5566_7788);
        step(1, 0, 2'b11, 1, B, 16'h0010, 0);
        // Negative displacement and address wrap.
        step(1, 1, 2'b10, 0, B + 32'h20, 16'hFFF4, 32'h0BAD_F00D);
        step(1, 0, 2'b10, 0, B, 16'h0014, 0);
        step(1, 1, 2'b10, 0, 32'hFFFF_FFF8, 16'h0020, 32'hCAFE_0001);
        step(1, 0, 2'b00, 1, 32'hFFFF_FFF8, 16'h0020, 0);
        step(1, 0, 2'b10, 0, 32'h0000_0030, 16'hFFE8, 0);
        // Idle cycles.
        step(0, 0, 2'b10, 0, B, 16'h0002, 0);
        step(0, 1, 2'b01, 0, B, 16'h0001, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule